// File: doc/BRIEF.md
# Stack-Managed Local/Global Register File

This block is a register file for a processor core whose procedure-call convention uses a stack of local registers. A bank of 128 local registers forms a circular stack addressed through a stack pointer. A separate bank of 64 global registers is reachable from any procedure. When a procedure is entered, the core asks for a frame of any size from 1 to 128 registers. The block moves the stack pointer down by exactly that amount, so a routine uses only the registers it needs. For example, one local variable plus a return address costs two registers. On exit the core releases the same count, the pointer moves back up, and those registers become free again.

Operands are named in one 8-bit address space. When the top bit is clear, the low seven bits are a local index counted from the stack pointer. The block maps that index onto the local bank modulo its size. When the top bit is set, the low bits select a global register directly. The live region is every register from the stack pointer upward that is still resident, so a callee can also reach its caller's registers above its own frame. An access outside that region, or past the last global register, is flagged and has no effect. There is no separate condition-code register; a comparison result goes into an ordinary register through the write port.

The block does not move data to or from memory. When a call would need more registers than are free, or a return would release more than are resident, the block raises a request and stalls the operation. The surrounding logic moves the data itself. It then acknowledges with a count of registers written out or brought back in, which updates the occupancy.

Top module: `rwin_file`

## Requirements
- R1: After reset the stack pointer is 0, the occupancy is 0, no request or stall is raised, and every register reads as zero.
- R2: A call (`call_i` high) with size n in 1..128 and occupancy + n <= 128 lowers the stack pointer by n modulo 128 and raises the occupancy by n, both visible after the next clock edge.
- R3: A return (`ret_i` high, `call_i` low) with size n in 1..128 and n <= occupancy raises the stack pointer by n modulo 128 and lowers the occupancy by n after the next edge.
- R4: A call or return whose size is 0 or greater than 128 is ignored. It changes no state and raises no request.
- R5: A call whose size would push the occupancy past 128 raises `spill_req_o` and `stall_o` in the same cycle and changes neither pointer nor occupancy. If `spill_ack_i` is high in such a cycle, the occupancy drops by min(`xfer_cnt_i`, occupancy) and the pointer is unchanged.
- R6: A return whose size exceeds the occupancy raises `fill_req_o` and `stall_o` and changes nothing. If `fill_ack_i` is high in such a cycle, the occupancy rises by min(`xfer_cnt_i`, 128 − occupancy) and the pointer is unchanged.
- R7: `spill_ack_i` and `fill_ack_i` have no effect in a cycle where the matching request is low.
- R8: When `call_i` and `ret_i` are both high, only the call is considered. The return has no effect in that cycle, and the two requests are never high together.
- R9: An address with bit 7 = 0 is local. Index i = bits 6:0 selects physical local register (stack pointer + i) mod 128, so after a call of n the caller's index i is reached as index i + n.
- R10: An address with bit 7 = 1 is global. Bits 6:0 select global register 0..63 regardless of the stack pointer, and a value of 64 or more is a fault.
- R11: A local index not below the current occupancy faults. A faulted read returns zero with its fault flag high, and a faulted write sets `w_fault_o` and leaves every register unchanged.
- R12: A write and a read of the same register in the same cycle return the data being written (write-through).
- R13: The two read ports work independently and at the same time on any pair of addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Request a new frame of `size_i` registers (held until not stalled) |
| ret_i | input | 1 | Release `size_i` registers (held until not stalled) |
| size_i | input | 8 | Frame size, valid 1..128 |
| spill_ack_i | input | 1 | External logic has written out `xfer_cnt_i` oldest registers |
| fill_ack_i | input | 1 | External logic has brought back `xfer_cnt_i` registers |
| xfer_cnt_i | input | 8 | Register count carried by an acknowledge |
| stall_o | output | 1 | Pending call or return cannot complete this cycle |
| spill_req_o | output | 1 | Call blocked for lack of free local registers |
| fill_req_o | output | 1 | Return blocked for lack of resident local registers |
| sp_o | output | 7 | Stack pointer |
| used_o | output | 8 | Number of resident live local registers |
| ra_addr_i | input | 8 | Read port A address |
| ra_data_o | output | 32 | Read port A data |
| ra_fault_o | output | 1 | Read port A address fault |
| rb_addr_i | input | 8 | Read port B address |
| rb_data_o | output | 32 | Read port B data |
| rb_fault_o | output | 1 | Read port B address fault |
| we_i | input | 1 | Write enable |
| wa_addr_i | input | 8 | Write address |
| wd_i | input | 32 | Write data |
| w_fault_o | output | 1 | Write address fault; write suppressed |

## Verification
The properties check every cycle that the occupancy never exceeds 128, that spill and fill requests never coincide, and that a stalled or idle cycle leaves the pointer unchanged. They also check that an accepted call or return moves the pointer or occupancy by exactly its size, that faulted reads return zero, and that write-through holds. Only the bench scenarios can show the modulo-128 address mapping across nested frames, caller registers reached at shifted indices, and the clamping of acknowledge counts. The same applies to the fact that a faulted write truly left storage alone: that needs a later fill to reopen the region and read it back.

// File: rtl/rwin_pkg.sv
`timescale 1ns/1ps
package rwin_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ALLOC = 2'd1,
    OP_FREE  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/rwin_stack_ctrl.sv
`timescale 1ns/1ps
module rwin_stack_ctrl
  import rwin_pkg::*;
#(
  parameter int unsigned NUM_LOCAL = 128,
  localparam int unsigned LOC_AW   = $clog2(NUM_LOCAL),
  localparam int unsigned CNT_W    = LOC_AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [CNT_W-1:0]  size_i,
  input  logic              spill_ack_i,
  input  logic              fill_ack_i,
  input  logic [CNT_W-1:0]  xfer_cnt_i,
  output logic [LOC_AW-1:0] sp_o,
  output logic [CNT_W-1:0]  used_o,
  output logic              spill_req_o,
  output logic              fill_req_o,
  output logic              stall_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_LOCAL);

  logic [LOC_AW-1:0] sp_q;
  logic [CNT_W-1:0]  used_q;
  logic              size_ok;
  logic [CNT_W:0]    sum;
  logic [CNT_W-1:0]  room, spill_amt, fill_amt;
  logic              spill_need, fill_need;
  stk_op_e           op;

  always_comb begin
    size_ok    = (size_i != '0) && (size_i <= FULL);
    sum        = {1'b0, used_q} + {1'b0, size_i};
    op         = OP_NONE;
    spill_need = 1'b0;
    fill_need  = 1'b0;
    if (call_i && size_ok) begin
      if (sum > {1'b0, FULL}) spill_need = 1'b1;
      else                    op = OP_ALLOC;
    end else if (!call_i && ret_i && size_ok) begin
      if (size_i > used_q) fill_need = 1'b1;
      else                 op = OP_FREE;
    end
  end

  // acknowledge counts clamp to what is resident / free
  always_comb begin
    room      = FULL - used_q;
    spill_amt = (xfer_cnt_i > used_q) ? used_q : xfer_cnt_i;
    fill_amt  = (xfer_cnt_i > room)   ? room   : xfer_cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q   <= '0;
      used_q <= '0;
    end else begin
      unique case (op)
        OP_ALLOC: begin
          sp_q   <= sp_q - size_i[LOC_AW-1:0];
          used_q <= used_q + size_i;
        end
        OP_FREE: begin
          sp_q   <= sp_q + size_i[LOC_AW-1:0];
          used_q <= used_q - size_i;
        end
        default: begin
          if (spill_need && spill_ack_i)     used_q <= used_q - spill_amt;
          else if (fill_need && fill_ack_i)  used_q <= used_q + fill_amt;
        end
      endcase
    end
  end

  assign sp_o        = sp_q;
  assign used_o      = used_q;
  assign spill_req_o = spill_need;
  assign fill_req_o  = fill_need;
  assign stall_o     = spill_need | fill_need;
endmodule

// File: rtl/rwin_xlate.sv
`timescale 1ns/1ps
module rwin_xlate #(
  parameter int unsigned NUM_LOCAL  = 128,
  parameter int unsigned NUM_GLOBAL = 64,
  localparam int unsigned LOC_AW    = $clog2(NUM_LOCAL),
  localparam int unsigned CNT_W     = LOC_AW + 1,
  localparam int unsigned FLAT_W    = $clog2(NUM_LOCAL + NUM_GLOBAL)
) (
  input  logic [LOC_AW:0]   addr_i,
  input  logic [LOC_AW-1:0] sp_i,
  input  logic [CNT_W-1:0]  used_i,
  output logic [FLAT_W-1:0] flat_o,
  output logic              fault_o
);
  localparam logic [LOC_AW-1:0] GLB_LIM  = LOC_AW'(NUM_GLOBAL);
  localparam logic [FLAT_W-1:0] GLB_BASE = FLAT_W'(NUM_LOCAL);

  logic [LOC_AW-1:0] idx, wrap;

  always_comb begin
    idx  = addr_i[LOC_AW-1:0];
    wrap = sp_i + idx;
    if (addr_i[LOC_AW]) begin
      fault_o = (idx >= GLB_LIM);
      flat_o  = GLB_BASE + FLAT_W'(idx);
    end else begin
      fault_o = ({1'b0, idx} >= used_i);
      flat_o  = FLAT_W'(wrap);
    end
  end
endmodule

// File: rtl/rwin_bank.sv
`timescale 1ns/1ps
module rwin_bank #(
  parameter int unsigned NUM_LOCAL  = 128,
  parameter int unsigned NUM_GLOBAL = 64,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NRD        = 2,
  localparam int unsigned DEPTH     = NUM_LOCAL + NUM_GLOBAL,
  localparam int unsigned FLAT_W    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [FLAT_W-1:0] w_idx_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [FLAT_W-1:0] r_idx_i  [NRD],
  input  logic              r_ok_i   [NRD],
  output logic [DATA_W-1:0] r_data_o [NRD]
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[w_idx_i] <= wd_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_comb begin
      if (!r_ok_i[g])                          r_data_o[g] = '0;
      else if (we_i && (w_idx_i == r_idx_i[g])) r_data_o[g] = wd_i;
      else                                     r_data_o[g] = mem_q[r_idx_i[g]];
    end
  end
endmodule

// File: rtl/rwin_file.sv
`timescale 1ns/1ps
module rwin_file #(
  parameter int unsigned NUM_LOCAL  = 128,
  parameter int unsigned NUM_GLOBAL = 64,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned LOC_AW    = $clog2(NUM_LOCAL),
  localparam int unsigned CNT_W     = LOC_AW + 1,
  localparam int unsigned AW        = LOC_AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [CNT_W-1:0]  size_i,
  input  logic              spill_ack_i,
  input  logic              fill_ack_i,
  input  logic [CNT_W-1:0]  xfer_cnt_i,
  output logic              stall_o,
  output logic              spill_req_o,
  output logic              fill_req_o,
  output logic [LOC_AW-1:0] sp_o,
  output logic [CNT_W-1:0]  used_o,
  input  logic [AW-1:0]     ra_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  output logic              ra_fault_o,
  input  logic [AW-1:0]     rb_addr_i,
  output logic [DATA_W-1:0] rb_data_o,
  output logic              rb_fault_o,
  input  logic              we_i,
  input  logic [AW-1:0]     wa_addr_i,
  input  logic [DATA_W-1:0] wd_i,
  output logic              w_fault_o
);
  localparam int unsigned NRD    = 2;
  localparam int unsigned NPORT  = NRD + 1;
  localparam int unsigned WP     = NRD;
  localparam int unsigned FLAT_W = $clog2(NUM_LOCAL + NUM_GLOBAL);

  logic [LOC_AW-1:0] sp;
  logic [CNT_W-1:0]  used;
  logic [AW-1:0]     addr_v  [NPORT];
  logic [FLAT_W-1:0] flat_v  [NPORT];
  logic              fault_v [NPORT];
  logic [FLAT_W-1:0] rd_idx  [NRD];
  logic              rd_ok   [NRD];
  logic [DATA_W-1:0] rd_data [NRD];

  rwin_stack_ctrl #(.NUM_LOCAL(NUM_LOCAL)) u_stk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .size_i      (size_i),
    .spill_ack_i (spill_ack_i),
    .fill_ack_i  (fill_ack_i),
    .xfer_cnt_i  (xfer_cnt_i),
    .sp_o        (sp),
    .used_o      (used),
    .spill_req_o (spill_req_o),
    .fill_req_o  (fill_req_o),
    .stall_o     (stall_o)
  );

  assign addr_v[0]  = ra_addr_i;
  assign addr_v[1]  = rb_addr_i;
  assign addr_v[WP] = wa_addr_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_xl
    rwin_xlate #(.NUM_LOCAL(NUM_LOCAL), .NUM_GLOBAL(NUM_GLOBAL)) u_xl (
      .addr_i  (addr_v[p]),
      .sp_i    (sp),
      .used_i  (used),
      .flat_o  (flat_v[p]),
      .fault_o (fault_v[p])
    );
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rdmap
    assign rd_idx[r] = flat_v[r];
    assign rd_ok[r]  = !fault_v[r];
  end

  rwin_bank #(
    .NUM_LOCAL (NUM_LOCAL),
    .NUM_GLOBAL(NUM_GLOBAL),
    .DATA_W    (DATA_W),
    .NRD       (NRD)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i && !fault_v[WP]),
    .w_idx_i  (flat_v[WP]),
    .wd_i     (wd_i),
    .r_idx_i  (rd_idx),
    .r_ok_i   (rd_ok),
    .r_data_o (rd_data)
  );

  assign sp_o       = sp;
  assign used_o     = used;
  assign ra_data_o  = rd_data[0];
  assign rb_data_o  = rd_data[1];
  assign ra_fault_o = fault_v[0];
  assign rb_fault_o = fault_v[1];
  assign w_fault_o  = fault_v[WP];
endmodule

// File: rtl/rwin_file_chk.sv
`timescale 1ns/1ps
module rwin_file_chk #(
  parameter int unsigned NUM_LOCAL = 128,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned LOC_AW   = $clog2(NUM_LOCAL),
  localparam int unsigned CNT_W    = LOC_AW + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              call_i,
  input logic              ret_i,
  input logic [CNT_W-1:0]  size_i,
  input logic              spill_ack_i,
  input logic              fill_ack_i,
  input logic              stall_o,
  input logic              spill_req_o,
  input logic              fill_req_o,
  input logic [LOC_AW-1:0] sp_o,
  input logic [CNT_W-1:0]  used_o,
  input logic [LOC_AW:0]   ra_addr_i,
  input logic [DATA_W-1:0] ra_data_o,
  input logic              ra_fault_o,
  input logic [DATA_W-1:0] rb_data_o,
  input logic              rb_fault_o,
  input logic              we_i,
  input logic [LOC_AW:0]   wa_addr_i,
  input logic [DATA_W-1:0] wd_i,
  input logic              w_fault_o
);
  logic size_ok;
  assign size_ok = (size_i != '0) && (size_i <= CNT_W'(NUM_LOCAL));

  AST_USED_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_o <= CNT_W'(NUM_LOCAL)); // R5

  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(spill_req_o && fill_req_o)); // R8

  AST_STALL_SP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> sp_o == $past(sp_o)); // R6

  AST_CALL_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_i && size_ok && !stall_o |=> sp_o == $past(sp_o) - $past(size_i[LOC_AW-1:0])); // R2

  AST_RET_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !call_i && ret_i && size_ok && !stall_o |=> used_o == $past(used_o) - $past(size_i)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !call_i && !ret_i |=> used_o == $past(used_o) && sp_o == $past(sp_o)); // R7

  AST_FAULT_ZERO_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_fault_o |-> ra_data_o == '0); // R11

  AST_FAULT_ZERO_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_fault_o |-> rb_data_o == '0); // R11

  AST_EMPTY_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_o == '0 && !ra_addr_i[LOC_AW] |-> ra_fault_o); // R11

  AST_WRITE_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !w_fault_o && wa_addr_i == ra_addr_i |-> ra_data_o == wd_i); // R12
endmodule

bind rwin_file rwin_file_chk #(.NUM_LOCAL(NUM_LOCAL), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .call_i      (call_i),
  .ret_i       (ret_i),
  .size_i      (size_i),
  .spill_ack_i (spill_ack_i),
  .fill_ack_i  (fill_ack_i),
  .stall_o     (stall_o),
  .spill_req_o (spill_req_o),
  .fill_req_o  (fill_req_o),
  .sp_o        (sp_o),
  .used_o      (used_o),
  .ra_addr_i   (ra_addr_i),
  .ra_data_o   (ra_data_o),
  .ra_fault_o  (ra_fault_o),
  .rb_data_o   (rb_data_o),
  .rb_fault_o  (rb_fault_o),
  .we_i        (we_i),
  .wa_addr_i   (wa_addr_i),
  .wd_i        (wd_i),
  .w_fault_o   (w_fault_o)
);

// File: tb/rwin_file_bench.sv
`timescale 1ns/1ps
module rwin_file_bench;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        call_i, ret_i, spill_ack_i, fill_ack_i, we_i;
  logic [7:0]  size_i, xfer_cnt_i, ra_addr_i, rb_addr_i, wa_addr_i;
  logic [31:0] wd_i, ra_data_o, rb_data_o;
  logic        stall_o, spill_req_o, fill_req_o, ra_fault_o, rb_fault_o, w_fault_o;
  logic [6:0]  sp_o;
  logic [7:0]  used_o;

  int n_cmp = 0;
  int n_bad = 0;
  int msp   = 0;
  int mused = 0;
  logic [31:0] mloc [128];
  logic [31:0] mglb [64];

  always #5 clk = ~clk; // 100 MHz

  rwin_file u_rwin_file (
    .clk_i(clk), .rst_ni(rst_ni), .call_i(call_i), .ret_i(ret_i), .size_i(size_i),
    .spill_ack_i(spill_ack_i), .fill_ack_i(fill_ack_i), .xfer_cnt_i(xfer_cnt_i),
    .stall_o(stall_o), .spill_req_o(spill_req_o), .fill_req_o(fill_req_o),
    .sp_o(sp_o), .used_o(used_o),
    .ra_addr_i(ra_addr_i), .ra_data_o(ra_data_o), .ra_fault_o(ra_fault_o),
    .rb_addr_i(rb_addr_i), .rb_data_o(rb_data_o), .rb_fault_o(rb_fault_o),
    .we_i(we_i), .wa_addr_i(wa_addr_i), .wd_i(wd_i), .w_fault_o(w_fault_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_fault(input logic [7:0] a);
    if (a[7]) return int'(a[6:0]) >= 64;
    return int'(a[6:0]) >= mused;
  endfunction

  function automatic logic [31:0] exp_data(input logic [7:0] a);
    if (exp_fault(a)) return 32'h0;
    if (a[7]) return mglb[a[5:0]];
    return mloc[(msp + int'(a[6:0])) % 128];
  endfunction

  task automatic rd(input logic [7:0] a, input logic [7:0] b, input string req);
    ra_addr_i = a;
    rb_addr_i = b;
    #1;
    chk(req, "ra_data", ra_data_o, exp_data(a));
    chk(req, "ra_fault", {31'h0, ra_fault_o}, {31'h0, exp_fault(a)});
    chk(req, "rb_data", rb_data_o, exp_data(b));
    chk(req, "rb_fault", {31'h0, rb_fault_o}, {31'h0, exp_fault(b)});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    bit f;
    @(negedge clk);
    we_i = 1'b1; wa_addr_i = a; wd_i = d; ra_addr_i = a;
    #1;
    f = exp_fault(a);
    chk(req, "w_fault", {31'h0, w_fault_o}, {31'h0, f});
    if (!f) chk("R12", "bypass", ra_data_o, d);
    @(posedge clk);
    #1;
    we_i = 1'b0;
    if (!f) begin
      if (a[7]) mglb[a[5:0]] = d;
      else      mloc[(msp + int'(a[6:0])) % 128] = d;
    end
  endtask

  task automatic op(input bit c, input bit r, input int n, input bit sa, input bit fa,
                    input int cnt, input string req);
    bit ok, cok, rok, nsp, nfl;
    @(negedge clk);
    call_i = c; ret_i = r; size_i = 8'(n);
    spill_ack_i = sa; fill_ack_i = fa; xfer_cnt_i = 8'(cnt);
    #1;
    ok  = (n >= 1) && (n <= 128);
    cok = c && ok;
    rok = !c && r && ok;
    nsp = cok && (mused + n > 128);
    nfl = rok && (n > mused);
    chk(req, "spill_req", {31'h0, spill_req_o}, {31'h0, nsp});
    chk(req, "fill_req", {31'h0, fill_req_o}, {31'h0, nfl});
    chk(req, "stall", {31'h0, stall_o}, {31'h0, nsp | nfl});
    if (cok && !nsp) begin
      msp = (msp - n + 256) % 128; mused += n;
    end else if (rok && !nfl) begin
      msp = (msp + n) % 128; mused -= n;
    end else if (nsp && sa) begin
      mused -= (cnt > mused) ? mused : cnt;
    end else if (nfl && fa) begin
      mused += (cnt > 128 - mused) ? (128 - mused) : cnt;
    end
    @(posedge clk);
    #1;
    call_i = 1'b0; ret_i = 1'b0; spill_ack_i = 1'b0; fill_ack_i = 1'b0;
    chk(req, "sp", {25'h0, sp_o}, 32'(msp));
    chk(req, "used", {24'h0, used_o}, 32'(mused));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mloc[i] = 32'h0;
    for (int i = 0; i < 64; i++)  mglb[i] = 32'h0;
    rst_ni = 1'b0; call_i = 0; ret_i = 0; size_i = 0; spill_ack_i = 0; fill_ack_i = 0;
    xfer_cnt_i = 0; we_i = 0; wa_addr_i = 0; wd_i = 0; ra_addr_i = 0; rb_addr_i = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "sp", {25'h0, sp_o}, 32'h0);
    chk("R1", "used", {24'h0, used_o}, 32'h0);
    chk("R1", "stall", {31'h0, stall_o | spill_req_o | fill_req_o}, 32'h0);
    for (int g = 0; g < 64; g++) rd(8'(128 + g), 8'(128 + 63 - g), "R1");
    rd(8'h00, 8'h7F, "R11");

    // R10 globals, R13 dual port
    for (int g = 0; g < 64; g++) wr(8'(128 + g), 32'hA500_0000 + 32'(g * 3), "R10");
    for (int g = 0; g < 64; g++) rd(8'(128 + g), 8'(128 + 63 - g), "R13");
    for (int g = 64; g < 128; g += 7) rd(8'(128 + g), 8'(128 + g - 64), "R10");
    wr(8'hC5, 32'h1234_5678, "R10");
    rd(8'h85, 8'hC5, "R10");

    // R4 invalid sizes, R7 stray acks
    op(1, 0, 0, 0, 0, 0, "R4");
    op(1, 0, 129, 0, 0, 0, "R4");
    op(0, 1, 200, 0, 0, 0, "R4");
    op(0, 0, 1, 1, 1, 5, "R7");
    op(0, 1, 0, 1, 1, 9, "R7");

    // R2 call, R9 mapping
    op(1, 0, 5, 0, 0, 0, "R2");
    for (int i = 0; i < 5; i++) wr(8'(i), 32'hB000_0000 + 32'(i), "R9");
    rd(8'h05, 8'h04, "R11");
    op(1, 0, 3, 0, 0, 0, "R2");
    for (int i = 0; i < 5; i++) rd(8'(i + 3), 8'(128 + i), "R9");
    for (int i = 0; i < 3; i++) wr(8'(i), 32'hC000_0000 + 32'(i), "R9");
    op(1, 1, 2, 0, 0, 0, "R8");
    op(0, 1, 2, 0, 0, 0, "R3");
    for (int i = 0; i < 8; i++) rd(8'(i), 8'(7 - i), "R9");

    // R5 overflow, spill
    op(1, 0, 125, 0, 0, 0, "R5");
    op(1, 0, 125, 1, 0, 5, "R5");
    op(1, 0, 125, 0, 0, 0, "R2");
    rd(8'h7F, 8'h00, "R9");
    op(1, 0, 1, 0, 0, 0, "R5");
    op(1, 0, 1, 1, 0, 200, "R5");
    op(1, 0, 1, 0, 0, 0, "R2");

    // R6 underflow, fill; R11 write suppression
    op(0, 1, 4, 0, 0, 0, "R6");
    wr(8'h02, 32'hDEAD_BEEF, "R11");
    op(0, 1, 4, 0, 1, 10, "R6");
    rd(8'h02, 8'h01, "R11");
    op(0, 1, 4, 0, 0, 0, "R3");
    op(0, 1, 100, 0, 0, 0, "R6");
    op(0, 1, 100, 0, 1, 255, "R6");
    op(0, 1, 100, 0, 0, 0, "R3");

    // full-window sweep
    op(1, 0, 100, 0, 0, 0, "R2");
    for (int i = 0; i < 128; i++) wr(8'(i), 32'h1000_0000 + 32'(i * 7), "R9");
    for (int i = 0; i < 128; i++) rd(8'(i), 8'(127 - i), "R13");
    op(0, 1, 64, 0, 0, 0, "R3");
    for (int i = 0; i < 64; i++) rd(8'(i), 8'(64 + i), "R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule